// File: doc/BRIEF.md
# Default Internal Class-of-Service Derivation

This block sits in the ingress path and produces a 3-bit internal class-of-service value for packets that arrive with no QoS policy attached. The parser upstream supplies the header fields it already extracted: the outer VLAN priority bits, the IP precedence and the EXP bits of the topmost MPLS label. The block also receives a flag for each of the VLAN tag and the MPLS label. It picks the trusted field by interface kind and tagging. The resulting value is later used only to mark newly imposed labels or tags, so the block never rewrites the packet's own precedence or DSCP.

Alongside the CoS value, the block selects one of three queues that sit in front of the processing pipeline. These are network control, high priority and low priority. A fourth queue index exists but is never chosen.

Results are registered. One cycle after a valid input, the block presents the CoS value, the queue index and a one-cycle valid strobe. An explicit-null top label is not treated as a special case: its EXP bits arrive on the same field as any other top label's EXP and are used the same way.

Top module: `default_cos_deriver`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid is 0, outCos is 0 and outQueue is 0.
- R2: A cycle with inValid high produces outValid high on the next rising edge for exactly one cycle. Back-to-back inputs yield back-to-back results. Between results, outCos and outQueue hold their last values whatever the inputs do.
- R3: On a bridged interface (ifType 0) with vlanPresent 1, outCos equals vlanPcp.
- R4: On a bridged interface (ifType 0) with vlanPresent 0, outCos is 0 whatever vlanPcp, ipPrec and topExp carry.
- R5: On a routed main interface (ifType 1), outCos equals ipPrec whether or not a tag is present.
- R6: On a routed sub-interface (ifType 2), outCos equals ipPrec and vlanPcp has no effect.
- R7: On an MPLS interface (ifType 3) with labelPresent 1, outCos equals topExp whether or not a VLAN tag is present, and vlanPcp and ipPrec have no effect.
- R8: On an MPLS interface (ifType 3) with labelPresent 0, outCos equals ipPrec.
- R9: outQueue is 0 (network control) when outCos is 6 or 7, 1 (high) when outCos is 5, and 2 (low) when outCos is 0 to 4. The value 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Header fields on the inputs are valid this cycle |
| ifType | input | 2 | Interface kind: 0 bridged, 1 routed main, 2 routed sub-interface, 3 MPLS |
| vlanPresent | input | 1 | Packet carries an outer VLAN tag |
| vlanPcp | input | 3 | Priority bits of the outer VLAN tag |
| ipPrec | input | 3 | IP precedence of the packet |
| labelPresent | input | 1 | Packet carries at least one MPLS label |
| topExp | input | 3 | EXP bits of the topmost label, explicit null included |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outCos | output | 3 | Derived internal class of service |
| outQueue | output | 2 | Pre-pipeline queue index |

## Verification
The bench targets the cases where a wrong field would be trusted. One case is a tagged routed sub-interface carrying a PCP that differs from its precedence; a design that honoured the tag would return the PCP. Another is an MPLS packet with a VLAN tag and mismatched PCP and precedence; a design that let the tag win would return the PCP. Further cases are an MPLS packet with no label, which a careless design would read as EXP, and an untagged bridged packet with nonzero junk fields, which should yield 0. The queue thresholds are tested at CoS 4, 5 and 6, where an off-by-one would misplace a packet. Back-to-back inputs and held outputs during idle cycles expose a design that drops a result or lets the outputs follow the inputs.

// File: rtl/cos_pkg.sv
package cos_pkg;

  localparam int COS_W  = 3;
  localparam int QIDX_W = 2;
  localparam int IFT_W  = 2;

  typedef enum logic [IFT_W-1:0] {
    IF_BRIDGED = 2'd0,
    IF_ROUTED  = 2'd1,
    IF_SUBIF   = 2'd2,
    IF_MPLS    = 2'd3
  } ifKind_e;

  // queue indices in front of the processing pipeline
  localparam logic [QIDX_W-1:0] Q_NETCTRL = 2'd0;
  localparam logic [QIDX_W-1:0] Q_HIGH    = 2'd1;
  localparam logic [QIDX_W-1:0] Q_LOW     = 2'd2;
  localparam logic [QIDX_W-1:0] Q_SPARE   = 2'd3;

  // strobes from control to datapath; exactly one select is set when loading
  typedef struct packed {
    logic loadEn;
    logic usePcp;
    logic usePrec;
    logic useExp;
    logic useZero;
  } cosCtrl_t;

endpackage

// File: rtl/cos_sel_ctrl.sv
module cos_sel_ctrl
  import cos_pkg::*;
(
  input  logic             inValid,
  input  logic [IFT_W-1:0] ifType,
  input  logic             vlanPresent,
  input  logic             labelPresent,
  output cosCtrl_t         ctrl
);

  ifKind_e kind;
  assign kind = ifKind_e'(ifType);

  always_comb begin
    ctrl = '0;
    ctrl.loadEn = inValid;
    unique case (kind)
      IF_BRIDGED: begin
        if (vlanPresent) ctrl.usePcp  = 1'b1;
        else             ctrl.useZero = 1'b1;
      end
      IF_ROUTED, IF_SUBIF: begin
        // sub-interface tag priority is deliberately not trusted
        ctrl.usePrec = 1'b1;
      end
      IF_MPLS: begin
        if (labelPresent) ctrl.useExp  = 1'b1;
        else              ctrl.usePrec = 1'b1;
      end
      default: ctrl.useZero = 1'b1;
    endcase
  end

endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int NC_MIN_COS = 6,
  parameter int HI_COS     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cosCtrl_t          ctrl,
  input  logic [COS_W-1:0]  vlanPcp,
  input  logic [COS_W-1:0]  ipPrec,
  input  logic [COS_W-1:0]  topExp,
  output logic              outValid,
  output logic [COS_W-1:0]  outCos,
  output logic [QIDX_W-1:0] outQueue
);

  localparam logic [COS_W-1:0] NC_MIN = COS_W'(NC_MIN_COS);
  localparam logic [COS_W-1:0] HI_VAL = COS_W'(HI_COS);

  logic [COS_W-1:0]  cosNext;
  logic [QIDX_W-1:0] queueNext;

  // AND-OR select keeps the mux one level deep
  always_comb begin
    cosNext = ({COS_W{ctrl.usePcp}}  & vlanPcp)
            | ({COS_W{ctrl.usePrec}} & ipPrec)
            | ({COS_W{ctrl.useExp}}  & topExp);
  end

  always_comb begin
    if (cosNext >= NC_MIN)      queueNext = Q_NETCTRL;
    else if (cosNext == HI_VAL) queueNext = Q_HIGH;
    else                        queueNext = Q_LOW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCos   <= '0;
      outQueue <= '0;
    end else begin
      outValid <= ctrl.loadEn;
      if (ctrl.loadEn) begin
        outCos   <= cosNext;
        outQueue <= queueNext;
      end
    end
  end

endmodule

// File: rtl/default_cos_deriver.sv
module default_cos_deriver
  import cos_pkg::*;
#(
  parameter int NC_MIN_COS = 6,
  parameter int HI_COS     = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  ifType,
  input  logic        vlanPresent,
  input  logic [2:0]  vlanPcp,
  input  logic [2:0]  ipPrec,
  input  logic        labelPresent,
  input  logic [2:0]  topExp,
  output logic        outValid,
  output logic [2:0]  outCos,
  output logic [1:0]  outQueue
);

  cosCtrl_t selCtrl;

  cos_sel_ctrl ctrl_i (
    .inValid      (inValid),
    .ifType       (ifType),
    .vlanPresent  (vlanPresent),
    .labelPresent (labelPresent),
    .ctrl         (selCtrl)
  );

  cos_datapath #(
    .NC_MIN_COS (NC_MIN_COS),
    .HI_COS     (HI_COS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (selCtrl),
    .vlanPcp  (vlanPcp),
    .ipPrec   (ipPrec),
    .topExp   (topExp),
    .outValid (outValid),
    .outCos   (outCos),
    .outQueue (outQueue)
  );

endmodule

// File: rtl/default_cos_chk.sv
module default_cos_chk
  import cos_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [1:0] ifType,
  input logic       vlanPresent,
  input logic [2:0] vlanPcp,
  input logic [2:0] ipPrec,
  input logic       labelPresent,
  input logic [2:0] topExp,
  input logic       outValid,
  input logic [2:0] outCos,
  input logic [1:0] outQueue,
  input cosCtrl_t   selCtrl
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outCos) && $stable(outQueue)));
  // R3
  bridged_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ifType == 2'd0 && vlanPresent) |=> outCos == $past(vlanPcp));
  // R4
  bridged_untag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ifType == 2'd0 && !vlanPresent) |=> outCos == 3'd0);
  // R5 R6
  routed_prec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (ifType == 2'd1 || ifType == 2'd2)) |=> outCos == $past(ipPrec));
  // R7
  mpls_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ifType == 2'd3 && labelPresent) |=> outCos == $past(topExp));
  // R8
  mpls_nolabel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ifType == 2'd3 && !labelPresent) |=> outCos == $past(ipPrec));
  // R9
  queue_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outCos >= 3'd6) == (outQueue == Q_NETCTRL)) &&
                 ((outCos == 3'd5) == (outQueue == Q_HIGH)) &&
                 (outQueue != Q_SPARE));
  // R3 R4 R5 R6 R7 R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> $countones({selCtrl.usePcp, selCtrl.usePrec,
                            selCtrl.useExp, selCtrl.useZero}) == 1);

endmodule

bind default_cos_deriver default_cos_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .ifType       (ifType),
  .vlanPresent  (vlanPresent),
  .vlanPcp      (vlanPcp),
  .ipPrec       (ipPrec),
  .labelPresent (labelPresent),
  .topExp       (topExp),
  .outValid     (outValid),
  .outCos       (outCos),
  .outQueue     (outQueue),
  .selCtrl      (selCtrl)
);

// File: tb/default_cos_deriver_tb.sv
module default_cos_deriver_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [1:0] ifType;
  logic       vlanPresent;
  logic [2:0] vlanPcp;
  logic [2:0] ipPrec;
  logic       labelPresent;
  logic [2:0] topExp;
  logic       outValid;
  logic [2:0] outCos;
  logic [1:0] outQueue;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  default_cos_deriver dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ifType(ifType),
    .vlanPresent(vlanPresent), .vlanPcp(vlanPcp), .ipPrec(ipPrec),
    .labelPresent(labelPresent), .topExp(topExp),
    .outValid(outValid), .outCos(outCos), .outQueue(outQueue)
  );

  function automatic logic [2:0] expCosOf(input logic [1:0] t, input logic vp,
      input logic [2:0] pcp, input logic [2:0] prec, input logic lp, input logic [2:0] ex);
    case (t)
      2'd0:    return vp ? pcp : 3'd0;
      2'd1:    return prec;
      2'd2:    return prec;
      default: return lp ? ex : prec;
    endcase
  endfunction

  function automatic logic [1:0] expQueueOf(input logic [2:0] c);
    if (c >= 3'd6) return 2'd0;
    if (c == 3'd5) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic vp, input logic [2:0] pcp,
      input logic [2:0] prec, input logic lp, input logic [2:0] ex);
    inValid = 1'b1; ifType = t; vlanPresent = vp; vlanPcp = pcp;
    ipPrec = prec; labelPresent = lp; topExp = ex;
  endtask

  task automatic checkOut(input string req, input logic [2:0] c);
    check(req, "outValid", outValid, 1);
    check(req, "outCos", outCos, c);
    check("R9", "outQueue", outQueue, expQueueOf(c));
  endtask

  // one packet: drive at negedge, result appears after the next posedge
  task automatic sendOne(input string req, input logic [1:0] t, input logic vp,
      input logic [2:0] pcp, input logic [2:0] prec, input logic lp, input logic [2:0] ex);
    @(negedge clk);
    drive(t, vp, pcp, prec, lp, ex);
    @(negedge clk);
    inValid = 1'b0;
    checkOut(req, expCosOf(t, vp, pcp, prec, lp, ex));
  endtask

  task automatic testReset();
    check("R1", "outValid in reset", outValid, 0);
    check("R1", "outCos in reset", outCos, 0);
    check("R1", "outQueue in reset", outQueue, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", outValid, 0);
    check("R1", "outCos after reset", outCos, 0);
    check("R1", "outQueue after reset", outQueue, 0);
  endtask

  task automatic testBridgedTagged();
    for (int p = 0; p < 8; p++)
      sendOne("R3", 2'd0, 1'b1, 3'(p), 3'(7 - p), 1'b1, 3'(p ^ 3));
  endtask

  task automatic testBridgedUntagged();
    sendOne("R4", 2'd0, 1'b0, 3'd7, 3'd6, 1'b1, 3'd5);
    sendOne("R4", 2'd0, 1'b0, 3'd3, 3'd2, 1'b0, 3'd1);
  endtask

  task automatic testRoutedMain();
    sendOne("R5", 2'd1, 1'b0, 3'd0, 3'd4, 1'b0, 3'd7);
    sendOne("R5", 2'd1, 1'b1, 3'd7, 3'd2, 1'b0, 3'd6);
  endtask

  task automatic testSubIf();
    for (int p = 0; p < 8; p++)
      sendOne("R6", 2'd2, 1'b1, 3'(7 - p), 3'(p), 1'b0, 3'd7);
  endtask

  task automatic testMplsLabel();
    sendOne("R7", 2'd3, 1'b0, 3'd7, 3'd7, 1'b1, 3'd1);
    sendOne("R7", 2'd3, 1'b1, 3'd0, 3'd0, 1'b1, 3'd6);
    sendOne("R7", 2'd3, 1'b1, 3'd7, 3'd1, 1'b1, 3'd5);
  endtask

  task automatic testMplsNoLabel();
    sendOne("R8", 2'd3, 1'b1, 3'd1, 3'd6, 1'b0, 3'd2);
    sendOne("R8", 2'd3, 1'b0, 3'd0, 3'd5, 1'b0, 3'd7);
  endtask

  task automatic testQueueEdges();
    sendOne("R9", 2'd1, 1'b0, 3'd0, 3'd4, 1'b0, 3'd0);
    sendOne("R9", 2'd1, 1'b0, 3'd0, 3'd5, 1'b0, 3'd0);
    sendOne("R9", 2'd1, 1'b0, 3'd0, 3'd6, 1'b0, 3'd0);
    sendOne("R9", 2'd1, 1'b0, 3'd0, 3'd7, 1'b0, 3'd0);
  endtask

  task automatic testBackToBackAndHold();
    @(negedge clk);
    drive(2'd2, 1'b1, 3'd0, 3'd6, 1'b0, 3'd0);
    @(negedge clk);
    drive(2'd3, 1'b0, 3'd0, 3'd0, 1'b1, 3'd5);
    checkOut("R2", 3'd6);
    @(negedge clk);
    inValid = 1'b0;
    checkOut("R2", 3'd5);
    // idle cycles with changing inputs: outputs hold, strobe stays low
    for (int i = 0; i < 3; i++) begin
      ifType = 2'd1; ipPrec = 3'(i); vlanPcp = 3'(i + 1); topExp = 3'd0;
      @(negedge clk);
      check("R2", "outValid idle", outValid, 0);
      check("R2", "outCos held", outCos, 5);
      check("R2", "outQueue held", outQueue, 1);
    end
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; ifType = 2'd0; vlanPresent = 1'b0;
    vlanPcp = 3'd0; ipPrec = 3'd0; labelPresent = 1'b0; topExp = 3'd0;
    repeat (3) @(negedge clk);
    testReset();
    testBridgedTagged();
    testBridgedUntagged();
    testRoutedMain();
    testSubIf();
    testMplsLabel();
    testMplsNoLabel();
    testQueueEdges();
    testBackToBackAndHold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule